// File: doc/BRIEF.md
# External Memory Bus Controller

This block extends a CPU's data address space past the top of internal SRAM. Once it is switched on, any data access whose address lies above the internal SRAM top goes out on an external parallel bus. That bus can serve SRAM, flash or memory-mapped peripherals. While the external access runs, the block tells the CPU to wait. When it is switched off, addresses above the internal SRAM top go nowhere. Addresses at or below the internal SRAM top are never handled here.

The external space is divided into a lower sector and an upper sector. The address that separates them is programmable. Each sector has its own two-bit wait code, which adds zero to three cycles to the phase in which the strobe is active.

An external access has three parts:
- an address cycle,
- a strobe phase,
- one completion cycle, in which read data is handed to the CPU.

The low address byte is always driven while the block is enabled. A configuration count sets how many high-address bits are also driven, starting from the lowest of them. The remaining high pins are released. The data bus has a separate output-enable, so an external pad can put it in the high-impedance state.

The CPU side works as follows:
- `cpu_req` is a one-cycle pulse for each access.
- `cpu_stall` is combinational in the request cycle and then registered.
- A new request may be issued in the completion cycle of the previous access.

Top module: `xbus_ctrl`

## Requirements
- R1: With `cfg_en` low, no request causes a strobe, a stall or a driven data bus, and every bit of `ext_addr_oe` is 0.
- R2: With `cfg_en` high, a request to an address at or below the internal SRAM top (default 0x10FF) causes no strobe and no stall.
- R3: With `cfg_en` high, a request above the SRAM top gives one address cycle, then a strobe phase on `ext_rd_n` (read) or `ext_wr_n` (write), then one completion cycle. `ext_addr` carries the request address during the strobe.
- R4: An address greater than or equal to `cfg_bound` uses `cfg_ws_hi`. A lower address uses `cfg_ws_lo`.
- R5: Wait code w (0..3) makes the strobe stay low for w+1 cycles. `cpu_stall` is high for exactly w+3 cycles, starting with the request cycle.
- R6: Read data is sampled from `ext_data_i` at the clock edge that ends the strobe. It appears on `cpu_rdata` with `cpu_rvalid` high during the completion cycle.
- R7: For a write, `ext_data_oe` is high and `ext_data_o` equals the write data through the whole strobe phase and the completion cycle. `ext_data_oe` is low at all other times.
- R8: The strobes are active low and are never low together.
- R9: `ext_addr_oe` bits 7..0 equal `cfg_en`. High bit 8+i is enabled only when `cfg_en` is high and i < `cfg_hi_cnt`. A count above 8 enables all eight high bits. A released bit reads 0 on `ext_addr`.
- R10: A request issued in the completion cycle starts the next access at once, with the full stall length of that next access.
- R11: After reset both strobes are high, `cpu_stall` and `cpu_rvalid` are low, and `ext_data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | External bus enable |
| cfg_bound | input | ADDR_W | First address of the upper sector |
| cfg_ws_lo | input | 2 | Wait code for the lower sector |
| cfg_ws_hi | input | 2 | Wait code for the upper sector |
| cfg_hi_cnt | input | clog2(HI_W+1) | Number of high-address bits driven |
| cpu_req | input | 1 | One-cycle access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Data address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_stall | output | 1 | CPU wait request |
| cpu_rdata | output | DATA_W | Captured read data |
| cpu_rvalid | output | 1 | Read data valid (completion cycle) |
| ext_addr | output | ADDR_W | External address |
| ext_addr_oe | output | ADDR_W | Per-pin address output enable |
| ext_data_o | output | DATA_W | External write data |
| ext_data_oe | output | 1 | External data output enable |
| ext_data_i | input | DATA_W | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
Two things can land in the same cycle: the completion of one access (read data handed over, write data still driven) and the acceptance of the next request. The bench provokes this by raising the next request inside the completion cycle of a read.

It then judges three things in that cycle:
- `cpu_rvalid` and `cpu_rdata` still carry the first read's data.
- The stall is counted for the second access and must equal its own wait code plus three.
- The strobes must never overlap at the hand-over.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int WS_W = 2;

  typedef enum logic [1:0] {
    XB_IDLE = 2'd0,
    XB_ADDR = 2'd1,
    XB_STRB = 2'd2,
    XB_DONE = 2'd3
  } xb_state_e;

  // Wait code chosen by sector: upper sector takes the high code.
  function automatic logic [WS_W-1:0] pick_ws(input logic upper,
                                              input logic [WS_W-1:0] lo,
                                              input logic [WS_W-1:0] hi);
    return upper ? hi : lo;
  endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SRAM_TOP = 16'h10FF
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] bound,
  input  logic [WS_W-1:0]   ws_lo,
  input  logic [WS_W-1:0]   ws_hi,
  output logic              hit,
  output logic [WS_W-1:0]   ws_sel
);
  logic upper;

  assign hit    = en && (addr > SRAM_TOP);
  assign upper  = (addr >= bound);
  assign ws_sel = pick_ws(upper, ws_lo, ws_hi);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WS_W-1:0] ws_in,
  output xb_state_e       state,
  output logic            last_strobe
);
  logic [WS_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= XB_IDLE;
      wait_cnt <= '0;
    end else begin
      unique case (state)
        XB_IDLE: if (start) begin
          state    <= XB_ADDR;
          wait_cnt <= ws_in;
        end
        XB_ADDR: state <= XB_STRB;
        XB_STRB: begin
          if (wait_cnt == '0) state <= XB_DONE;
          else wait_cnt <= wait_cnt - 1'b1;
        end
        XB_DONE: begin
          if (start) begin
            state    <= XB_ADDR;
            wait_cnt <= ws_in;
          end else begin
            state <= XB_IDLE;
          end
        end
        default: state <= XB_IDLE;
      endcase
    end
  end

  assign last_strobe = (state == XB_STRB) && (wait_cnt == '0);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins #(
  parameter int ADDR_W = 16,
  parameter int HI_W   = 8,
  localparam int LO_W  = ADDR_W - HI_W,
  localparam int CNT_W = $clog2(HI_W + 1)
) (
  input  logic              en,
  input  logic [CNT_W-1:0]  hi_cnt,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] pin_addr,
  output logic [ADDR_W-1:0] pin_oe
);
  logic [HI_W-1:0] hi_oe;

  // One enable per high-address pin: driven while its index is below the count.
  for (genvar gi = 0; gi < HI_W; gi++) begin : g_hi
    assign hi_oe[gi] = en && (CNT_W'(gi) < hi_cnt);
  end

  assign pin_oe   = {hi_oe, {LO_W{en}}};
  assign pin_addr = addr_q & pin_oe;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HI_W   = 8,
  parameter logic [ADDR_W-1:0] SRAM_TOP = 16'h10FF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_en,
  input  logic [ADDR_W-1:0]          cfg_bound,
  input  logic [1:0]                 cfg_ws_lo,
  input  logic [1:0]                 cfg_ws_hi,
  input  logic [$clog2(HI_W+1)-1:0]  cfg_hi_cnt,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic                       cpu_stall,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic                       cpu_rvalid,
  output logic [ADDR_W-1:0]          ext_addr,
  output logic [ADDR_W-1:0]          ext_addr_oe,
  output logic [DATA_W-1:0]          ext_data_o,
  output logic                       ext_data_oe,
  input  logic [DATA_W-1:0]          ext_data_i,
  output logic                       ext_rd_n,
  output logic                       ext_wr_n
);
  logic              hit;
  logic [WS_W-1:0]   ws_sel;
  logic              start;
  logic              last_strobe;
  logic              strobe_on;
  xb_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              we_q;

  xbus_decode #(.ADDR_W(ADDR_W), .SRAM_TOP(SRAM_TOP)) u_dec (
    .en(cfg_en), .addr(cpu_addr), .bound(cfg_bound),
    .ws_lo(cfg_ws_lo), .ws_hi(cfg_ws_hi), .hit(hit), .ws_sel(ws_sel)
  );

  assign start = cpu_req && hit && ((state == XB_IDLE) || (state == XB_DONE));

  xbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ws_in(ws_sel),
    .state(state), .last_strobe(last_strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        addr_q  <= cpu_addr;
        wdata_q <= cpu_wdata;
        we_q    <= cpu_we;
      end
      if (last_strobe && !we_q) rdata_q <= ext_data_i;
    end
  end

  xbus_pins #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_pins (
    .en(cfg_en), .hi_cnt(cfg_hi_cnt), .addr_q(addr_q),
    .pin_addr(ext_addr), .pin_oe(ext_addr_oe)
  );

  assign strobe_on   = (state == XB_STRB);
  assign ext_rd_n    = !(strobe_on && !we_q);
  assign ext_wr_n    = !(strobe_on && we_q);
  assign ext_data_oe = we_q && (strobe_on || (state == XB_DONE));
  assign ext_data_o  = wdata_q;
  assign cpu_stall   = start || (state == XB_ADDR) || strobe_on;
  assign cpu_rvalid  = (state == XB_DONE) && !we_q;
  assign cpu_rdata   = rdata_q;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int HI_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              start,
  input logic              we_q,
  input logic              cpu_stall,
  input logic              cpu_rvalid,
  input logic              ext_rd_n,
  input logic              ext_wr_n,
  input logic              ext_data_oe,
  input logic [ADDR_W-1:0] ext_addr_oe
);
  localparam int LO_W = ADDR_W - HI_W;

  logic [3:0]      strobe_run;
  logic [HI_W-1:0] hi_oe;
  logic [HI_W-1:0] hi_oe_p1;

  assign hi_oe    = ext_addr_oe[ADDR_W-1:LO_W];
  assign hi_oe_p1 = hi_oe + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_run <= '0;
    else if (!ext_rd_n || !ext_wr_n) strobe_run <= strobe_run + 1'b1;
    else strobe_run <= '0;
  end

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));
  p_off_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !start);
  p_strobe_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> cpu_stall);
  p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_run <= 4'd4);
  p_rvalid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> (ext_rd_n && $past(!ext_rd_n)));
  p_data_oe_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_data_oe |-> (we_q && ext_rd_n));
  p_hi_contig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_oe & hi_oe_p1) == '0);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .start(start), .we_q(we_q),
  .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .ext_rd_n(ext_rd_n),
  .ext_wr_n(ext_wr_n), .ext_data_oe(ext_data_oe), .ext_addr_oe(ext_addr_oe)
);

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;
  localparam logic [15:0] TOP = 16'h10FF;

  typedef struct packed {
    logic        en;
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [15:0] bound;
    logic [1:0]  ws_lo;
    logic [1:0]  ws_hi;
    logic [3:0]  hi_cnt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h2000, 8'h00, 16'h8000, 2'd3, 2'd3, 4'd8},
    '{1'b1, 1'b0, 16'h0800, 8'h00, 16'h8000, 2'd3, 2'd3, 4'd8},
    '{1'b1, 1'b0, 16'h2000, 8'h00, 16'h8000, 2'd0, 2'd3, 4'd8},
    '{1'b1, 1'b1, 16'h9000, 8'hA5, 16'h8000, 2'd1, 2'd3, 4'd8},
    '{1'b1, 1'b0, 16'h8123, 8'h00, 16'h8123, 2'd2, 2'd1, 4'd4},
    '{1'b1, 1'b0, 16'h8122, 8'h00, 16'h8123, 2'd2, 2'd1, 4'd0},
    '{1'b1, 1'b1, 16'h1100, 8'h3C, 16'h1100, 2'd1, 2'd0, 4'd12},
    '{1'b1, 1'b1, 16'h10FF, 8'h77, 16'h8000, 2'd2, 2'd2, 4'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic [15:0] cfg_bound = '0;
  logic [1:0] cfg_ws_lo = '0, cfg_ws_hi = '0;
  logic [3:0] cfg_hi_cnt = '0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_stall, cpu_rvalid, ext_data_oe, ext_rd_n, ext_wr_n;
  logic [7:0] cpu_rdata, ext_data_o, ext_data_i;
  logic [15:0] ext_addr, ext_addr_oe;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  // External device model: answers only while the read strobe is low.
  assign ext_data_i = !ext_rd_n ? (ext_addr[7:0] ^ 8'h5A) : 8'hEE;

  xbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bound(cfg_bound),
    .cfg_ws_lo(cfg_ws_lo), .cfg_ws_hi(cfg_ws_hi), .cfg_hi_cnt(cfg_hi_cnt),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .ext_addr(ext_addr), .ext_addr_oe(ext_addr_oe), .ext_data_o(ext_data_o),
    .ext_data_oe(ext_data_oe), .ext_data_i(ext_data_i),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pin_mask(input vec_t v);
    logic [15:0] m = '0;
    if (v.en) begin
      m[7:0] = 8'hFF;
      for (int i = 0; i < 8; i++) if (i < int'(v.hi_cnt)) m[8+i] = 1'b1;
    end
    return m;
  endfunction

  // Runs one access. Leaves time inside the completion cycle (or the next
  // cycle for an unserviced request).
  task automatic run_access(input vec_t v, input bit immediate);
    logic        hit;
    logic [1:0]  ws;
    int          stalls, strobes, wait_seen;
    bit          overlap, addr_ok, data_ok;
    hit = v.en && (v.addr > TOP);
    ws  = (v.addr >= v.bound) ? v.ws_hi : v.ws_lo;
    if (!immediate) @(negedge clk);
    cfg_en = v.en; cfg_bound = v.bound; cfg_ws_lo = v.ws_lo; cfg_ws_hi = v.ws_hi;
    cfg_hi_cnt = v.hi_cnt; cpu_we = v.we; cpu_addr = v.addr; cpu_wdata = v.wdata;
    cpu_req = 1'b1;
    stalls = 0; strobes = 0; wait_seen = 0;
    overlap = 0; addr_ok = 1; data_ok = 1;
    #1;
    while (cpu_stall && wait_seen < 20) begin
      wait_seen++;
      stalls++;
      if (!ext_rd_n && !ext_wr_n) overlap = 1;
      if (!ext_rd_n || !ext_wr_n) begin
        strobes++;
        if (ext_addr !== (v.addr & pin_mask(v))) addr_ok = 0;
        if (v.we && (!ext_data_oe || ext_data_o !== v.wdata)) data_ok = 0;
        if (v.we == ext_wr_n) data_ok = 0;
      end
      @(negedge clk); cpu_req = 1'b0; #1;
    end
    if (!hit) begin
      @(negedge clk); cpu_req = 1'b0; #1;
      check(ext_rd_n && ext_wr_n && !ext_data_oe, v.en ? "R2 no strobe internal" : "R1 no strobe disabled",
            {ext_rd_n, ext_wr_n, ext_data_oe}, 3'b110);
      check(stalls == 0, v.en ? "R2 no stall" : "R1 no stall", stalls, 0);
      if (!v.en) check(ext_addr_oe == 16'h0, "R1 addr released", ext_addr_oe, 0);
    end else begin
      check(stalls == int'(ws) + 3, "R5 stall length", stalls, int'(ws) + 3);
      check(strobes == int'(ws) + 1, "R4 R3 strobe length per sector", strobes, int'(ws) + 1);
      check(!overlap, "R8 strobes exclusive", overlap, 0);
      check(addr_ok, "R3 address during strobe", ext_addr, v.addr & pin_mask(v));
      check(ext_addr_oe == pin_mask(v), "R9 address pin enables", ext_addr_oe, pin_mask(v));
      if (v.we) begin
        check(data_ok && ext_data_oe && ext_data_o == v.wdata,
              "R7 write data driven strobe and completion", ext_data_o, v.wdata);
      end else begin
        check(cpu_rvalid && cpu_rdata == (v.addr[7:0] ^ 8'h5A), "R6 read data",
              {cpu_rvalid, cpu_rdata}, {1'b1, v.addr[7:0] ^ 8'h5A});
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vec_t vr, vw;
    #35;
    check(ext_rd_n && ext_wr_n && !cpu_stall && !ext_data_oe && !cpu_rvalid,
          "R11 reset state", {ext_rd_n, ext_wr_n, cpu_stall, ext_data_oe, cpu_rvalid}, 5'b11000);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      run_access(VECS[k], 1'b0);
      if (VECS[k].we && VECS[k].en && VECS[k].addr > TOP) begin
        @(negedge clk); #1;
        check(!ext_data_oe, "R7 data released after completion", ext_data_oe, 0);
      end
    end
    // R10: read, then a write issued inside the read's completion cycle.
    vr = '{1'b1, 1'b0, 16'h4321, 8'h00, 16'h8000, 2'd1, 2'd2, 4'd8};
    vw = '{1'b1, 1'b1, 16'hC0DE, 8'h96, 16'h8000, 2'd1, 2'd2, 4'd8};
    run_access(vr, 1'b0);
    run_access(vw, 1'b1);
    check(1'b1, "R10 back-to-back completed", 0, 0);
    // R10: write followed at once by a read in its completion cycle.
    vw.ws_hi = 2'd0;
    vr.addr = 16'hF00F;
    run_access(vw, 1'b0);
    run_access(vr, 1'b1);
    // R9: count above eight drives every high bit.
    @(negedge clk); cfg_hi_cnt = 4'd15; cfg_en = 1'b1; #1;
    check(ext_addr_oe == 16'hFFFF, "R9 count clamp", ext_addr_oe, 16'hFFFF);
    cfg_hi_cnt = 4'd3; #1;
    check(ext_addr_oe == 16'h07FF, "R9 count three", ext_addr_oe, 16'h07FF);
    // R11: reset in the middle of an access returns the idle state.
    run_access(VECS[2], 1'b0);
    @(negedge clk); cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'hA000; cfg_ws_hi = 2'd3;
    @(negedge clk); cpu_req = 1'b0; @(negedge clk);
    rst_n = 1'b0; #1;
    check(ext_rd_n && ext_wr_n && !cpu_stall && !ext_data_oe, "R11 reset mid access",
          {ext_rd_n, ext_wr_n, cpu_stall, ext_data_oe}, 4'b1100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule